// File: doc/BRIEF.md
# I2C Target Read-Response Engine

This block is the target side of an I2C bus for master reads. It watches SCL and SDA and waits for a start condition followed by an address byte. If the address matches one of its enabled identities, it answers on the ninth clock with an acknowledge level that software chooses. When the master asks to read, the block goes into transmit mode by itself. It then shifts out bytes that the host writes into a one-byte transmit register, MSB first. Both bus lines are driven open-drain, as pull-low enables.

The host side is a small register interface: a transmit-data write strobe, a dummy-read strobe with the last received byte, sticky status flags and clear strobes. The block stretches the clock whenever it cannot go on. This happens when no byte is waiting at the end of a byte slot, or when the master has refused a byte while refusal detection is on. In that case it holds SCL low from the ninth falling edge. A transmit write resumes the transfer, and a dummy read ends it. A stop condition clears the per-transfer state and returns the block to listening.

Top module: `i2c_tgt_tx`

## Requirements
- R1: After reset all status outputs (hit flags, transmit mode, transmit empty, transmit end, NACK flag, stop flag) are 0, and neither bus line is pulled.
- R2: After a start condition the 7-bit address (bits 7..1 of the first byte, R/W in bit 0) is compared with three own-address slots, each with its own enable, with the general-call address 0 (enabled by gc_en) and with the host address 7'h08 (enabled by host_en). The hit flags are bit0..bit2 for the slots, bit3 for general call and bit4 for host. A hit sets its bit at the rising edge of the ninth SCL clock. A miss or a disabled identity leaves SDA released on the ninth clock and sets no flag.
- R3: On a match, SDA is pulled low through the ninth clock when nack_addr is 0 and left released when nack_addr is 1.
- R4: When the R/W bit is 1 and the address is acknowledged, tx_mode and tx_empty rise at the ninth SCL rising edge. A read answered with NACK, or a write, leaves tx_mode at 0.
- R5: A tx_wr strobe is accepted only while tx_empty is 1. Any other write is dropped and never reaches the bus.
- R6: Data bytes go out MSB first, and the block changes its SDA drive only while SCL is low.
- R7: If no byte is waiting at the ninth falling edge, SCL is held low. A byte written while held releases SCL and is sent. When this follows a completed data byte, tx_end is set.
- R8: With nack_det_en at 1, a NACK from the master sets nack_flag and holds SCL low at the ninth falling edge. A byte already buffered is not sent.
- R9: With nack_det_en at 0, a NACK from the master is treated like an ACK, so the buffered byte is sent and nack_flag stays 0.
- R10: An rx_rd strobe during a hold releases SCL and ends the transfer. rx_data holds the received address byte.
- R11: A stop condition clears the hit flags, tx_mode, tx_empty and tx_end, sets stop_flag and returns the block to address listening.
- R12: nack_flag and stop_flag stay set until clr_nack or clr_stop clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull | output | 1 | Pull SCL low (clock stretch) |
| sda_pull | output | 1 | Pull SDA low |
| own_addr | input | 21 | Three 7-bit own addresses, slot 0 in the low bits |
| own_en | input | 3 | Per-slot enable |
| gc_en | input | 1 | General-call match enable |
| host_en | input | 1 | Host-address match enable |
| nack_addr | input | 1 | Address answer: 0 ACK, 1 NACK |
| nack_det_en | input | 1 | Stop transmitting on master NACK |
| tx_wr | input | 1 | Transmit-data write strobe |
| tx_data | input | 8 | Transmit data |
| rx_rd | input | 1 | Dummy-read strobe of the receive register |
| rx_data | output | 8 | Last received address byte |
| hit_flags | output | 5 | Match type flags |
| tx_mode | output | 1 | Transmit mode active |
| tx_empty | output | 1 | Transmit register may be written |
| tx_end | output | 1 | Byte finished with register empty |
| nack_flag | output | 1 | Master NACK seen (sticky) |
| stop_flag | output | 1 | Stop condition seen (sticky) |
| clr_nack | input | 1 | Clear nack_flag |
| clr_stop | input | 1 | Clear stop_flag |

## Verification
The address matcher is tried with each identity in turn, with a one-bit near miss and with a disabled slot. This separates a correct per-identity compare and a correct hit-bit position from loose or misrouted matching. Read transfers are run with the byte written before the address, written during the hold, written during a byte and written twice while the register is full. These separate the stretch, release and drop paths. Master NACK is applied with detection on and with detection off, which tells abort from continue. Stop is issued after every transfer to show that the flags are cleared and that stop_flag is sticky.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_TX,
    ST_DACK,
    ST_HOLD,
    ST_PARK
  } tgt_state_e;

  localparam int unsigned DEF_ADDR_W = 7;
  localparam int unsigned DEF_DATA_W = 8;

endpackage

// File: rtl/i2c_tgt_linemon.sv
module i2c_tgt_linemon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl  = scl_ff[STAGES-1];
  assign sda_lvl  = sda_ff[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_d;
  assign scl_fall = ~scl_lvl & scl_d;
  // SDA edge counts only if SCL was high on both samples
  assign start_ev = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match #(
  parameter int                N_OWN     = 3,
  parameter int                ADDR_W    = 7,
  parameter logic [ADDR_W-1:0] HOST_ADDR = 7'h08
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [N_OWN*ADDR_W-1:0] own_addr,
  input  logic [N_OWN-1:0]        own_en,
  input  logic                    gc_en,
  input  logic                    host_en,
  output logic [N_OWN+1:0]        hit
);

  for (genvar g = 0; g < N_OWN; g++) begin : g_slot
    assign hit[g] = own_en[g] && (addr == own_addr[g*ADDR_W +: ADDR_W]);
  end

  assign hit[N_OWN]   = gc_en && (addr == '0);
  assign hit[N_OWN+1] = host_en && (addr == HOST_ADDR);

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int N_OWN  = 3,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [N_OWN+1:0]  hit_vec,
  output logic [ADDR_W-1:0] addr_rx,
  input  logic              nack_addr,
  input  logic              nack_det_en,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rd,
  input  logic              clr_nack,
  input  logic              clr_stop,
  output logic [DATA_W-1:0] rx_data,
  output logic [N_OWN+1:0]  hit_flags,
  output logic              tx_mode,
  output logic              tx_empty,
  output logic              tx_end,
  output logic              nack_flag,
  output logic              stop_flag,
  output logic              scl_hold,
  output logic              sda_drv
);

  localparam int          CNT_W    = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);
  localparam int          MSB      = DATA_W - 1;

  tgt_state_e          state_q, state_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [DATA_W-1:0]   rx_sh_q, rx_sh_n;
  logic [DATA_W-1:0]   tx_sh_q, tx_sh_n;
  logic [DATA_W-1:0]   tx_buf_q, tx_buf_n;
  logic [DATA_W-1:0]   rx_data_q, rx_data_n;
  logic [N_OWN+1:0]    hit_q, hit_n;
  logic tx_full_q, tx_full_n;
  logic tx_mode_q, tx_mode_n;
  logic tx_end_q, tx_end_n;
  logic nack_q, nack_n;
  logic stop_q, stop_n;
  logic got_nack_q, got_nack_n;
  logic sda_q, sda_n;
  logic scl_q, scl_n;
  logic do_load;
  logic wr_ok;

  assign addr_rx = rx_sh_q[DATA_W-1 -: ADDR_W];
  assign wr_ok   = tx_wr && tx_mode_q && !tx_full_q;

  // next-state logic
  always_comb begin
    state_n    = state_q;
    cnt_n      = cnt_q;
    rx_sh_n    = rx_sh_q;
    tx_sh_n    = tx_sh_q;
    tx_buf_n   = tx_buf_q;
    rx_data_n  = rx_data_q;
    hit_n      = hit_q;
    tx_full_n  = tx_full_q;
    tx_mode_n  = tx_mode_q;
    tx_end_n   = tx_end_q;
    nack_n     = nack_q;
    stop_n     = stop_q;
    got_nack_n = got_nack_q;
    sda_n      = sda_q;
    scl_n      = scl_q;
    do_load    = 1'b0;

    if (wr_ok) begin
      tx_buf_n  = tx_data;
      tx_full_n = 1'b1;
    end
    if (clr_nack) nack_n = 1'b0;
    if (clr_stop) stop_n = 1'b0;

    if (stop_ev) begin
      state_n   = ST_IDLE;
      hit_n     = '0;
      tx_mode_n = 1'b0;
      tx_end_n  = 1'b0;
      tx_full_n = 1'b0;
      stop_n    = 1'b1;
      sda_n     = 1'b0;
      scl_n     = 1'b0;
    end else if (start_ev) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      sda_n   = 1'b0;
      scl_n   = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            rx_sh_n = {rx_sh_q[DATA_W-2:0], sda_lvl};
            cnt_n   = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            rx_data_n = rx_sh_q;
            if (|hit_vec) begin
              sda_n   = !nack_addr;
              state_n = ST_AACK;
            end else begin
              state_n = ST_PARK;
            end
          end
        end
        ST_AACK: begin
          if (scl_rise) begin
            hit_n = hit_vec;
            if (rx_sh_q[0] && !nack_addr) tx_mode_n = 1'b1;
          end else if (scl_fall) begin
            sda_n = 1'b0;
            if (!tx_mode_q) begin
              state_n = ST_PARK;
            end else if (tx_full_q) begin
              do_load = 1'b1;
            end else begin
              scl_n   = 1'b1;
              state_n = ST_HOLD;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              sda_n   = 1'b0;
              cnt_n   = '0;
              state_n = ST_DACK;
            end else begin
              tx_sh_n = {tx_sh_q[DATA_W-2:0], 1'b0};
              sda_n   = !tx_sh_q[MSB-1];
              cnt_n   = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_DACK: begin
          if (scl_rise) begin
            got_nack_n = sda_lvl;
          end else if (scl_fall) begin
            if (got_nack_q && nack_det_en) begin
              nack_n   = 1'b1;
              tx_end_n = !tx_full_q;
              scl_n    = 1'b1;
              state_n  = ST_HOLD;
            end else if (tx_full_q) begin
              do_load = 1'b1;
            end else begin
              tx_end_n = 1'b1;
              scl_n    = 1'b1;
              state_n  = ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (rx_rd) begin
            scl_n   = 1'b0;
            state_n = ST_PARK;
          end else if (tx_full_q && !nack_q) begin
            do_load = 1'b1;
            scl_n   = 1'b0;
          end
        end
        default: ;
      endcase
    end

    if (do_load) begin
      tx_sh_n   = tx_buf_q;
      tx_full_n = 1'b0;
      tx_end_n  = 1'b0;
      sda_n     = !tx_buf_q[MSB];
      cnt_n     = '0;
      state_n   = ST_TX;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      rx_sh_q    <= '0;
      tx_sh_q    <= '0;
      tx_buf_q   <= '0;
      rx_data_q  <= '0;
      hit_q      <= '0;
      tx_full_q  <= 1'b0;
      tx_mode_q  <= 1'b0;
      tx_end_q   <= 1'b0;
      nack_q     <= 1'b0;
      stop_q     <= 1'b0;
      got_nack_q <= 1'b0;
      sda_q      <= 1'b0;
      scl_q      <= 1'b0;
    end else begin
      state_q    <= state_n;
      cnt_q      <= cnt_n;
      rx_sh_q    <= rx_sh_n;
      tx_sh_q    <= tx_sh_n;
      tx_buf_q   <= tx_buf_n;
      rx_data_q  <= rx_data_n;
      hit_q      <= hit_n;
      tx_full_q  <= tx_full_n;
      tx_mode_q  <= tx_mode_n;
      tx_end_q   <= tx_end_n;
      nack_q     <= nack_n;
      stop_q     <= stop_n;
      got_nack_q <= got_nack_n;
      sda_q      <= sda_n;
      scl_q      <= scl_n;
    end
  end

  assign rx_data   = rx_data_q;
  assign hit_flags = hit_q;
  assign tx_mode   = tx_mode_q;
  assign tx_empty  = tx_mode_q & ~tx_full_q;
  assign tx_end    = tx_end_q;
  assign nack_flag = nack_q;
  assign stop_flag = stop_q;
  assign scl_hold  = scl_q;
  assign sda_drv   = sda_q;

  // R11: stop wipes the per-transfer state and raises the stop flag
  p_stop_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (hit_q == '0 && !tx_mode_q && !tx_end_q && stop_q));

  // R6: SDA drive only moves while the synchronized SCL is low
  p_sda_low_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_q) |-> (!$past(scl_lvl) || $past(start_ev) || $past(stop_ev)));

  // R7 / R8: a stretch only begins on a falling SCL edge
  p_hold_at_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_q) |-> $past(scl_fall));

  // R10: a stretch ends only on dummy read or on a waiting byte
  p_release_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_q) |-> $past(rx_rd || tx_full_q || start_ev || stop_ev));

  // R5: a write outside the empty window leaves the buffer untouched
  p_wr_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !tx_empty) |=> $stable(tx_buf_q));

  // R12: the NACK flag holds until cleared
  p_nack_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_q && !clr_nack) |=> nack_q);

  // R4: transmit mode is entered on a rising SCL edge
  p_txmode_at_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_mode_q) |-> $past(scl_rise));

endmodule

// File: rtl/i2c_tgt_tx.sv
module i2c_tgt_tx #(
  parameter int                N_OWN     = 3,
  parameter int                ADDR_W    = i2c_tgt_pkg::DEF_ADDR_W,
  parameter int                DATA_W    = i2c_tgt_pkg::DEF_DATA_W,
  parameter int                SYNC_STG  = 2,
  parameter logic [ADDR_W-1:0] HOST_ADDR = 7'h08
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    scl_pull,
  output logic                    sda_pull,
  input  logic [N_OWN*ADDR_W-1:0] own_addr,
  input  logic [N_OWN-1:0]        own_en,
  input  logic                    gc_en,
  input  logic                    host_en,
  input  logic                    nack_addr,
  input  logic                    nack_det_en,
  input  logic                    tx_wr,
  input  logic [DATA_W-1:0]       tx_data,
  input  logic                    rx_rd,
  output logic [DATA_W-1:0]       rx_data,
  output logic [N_OWN+1:0]        hit_flags,
  output logic                    tx_mode,
  output logic                    tx_empty,
  output logic                    tx_end,
  output logic                    nack_flag,
  output logic                    stop_flag,
  input  logic                    clr_nack,
  input  logic                    clr_stop
);

  localparam int HIT_W = N_OWN + 2;

  logic [1:0]        rst_sync;
  logic              rst_n_i;
  logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic [ADDR_W-1:0] addr_rx;
  logic [HIT_W-1:0]  hit_vec;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  i2c_tgt_linemon #(.STAGES(SYNC_STG)) u_linemon (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_tgt_match #(
    .N_OWN     (N_OWN),
    .ADDR_W    (ADDR_W),
    .HOST_ADDR (HOST_ADDR)
  ) u_match (
    .addr     (addr_rx),
    .own_addr (own_addr),
    .own_en   (own_en),
    .gc_en    (gc_en),
    .host_en  (host_en),
    .hit      (hit_vec)
  );

  i2c_tgt_engine #(
    .N_OWN  (N_OWN),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_engine (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .scl_lvl     (scl_lvl),
    .sda_lvl     (sda_lvl),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_ev    (start_ev),
    .stop_ev     (stop_ev),
    .hit_vec     (hit_vec),
    .addr_rx     (addr_rx),
    .nack_addr   (nack_addr),
    .nack_det_en (nack_det_en),
    .tx_wr       (tx_wr),
    .tx_data     (tx_data),
    .rx_rd       (rx_rd),
    .clr_nack    (clr_nack),
    .clr_stop    (clr_stop),
    .rx_data     (rx_data),
    .hit_flags   (hit_flags),
    .tx_mode     (tx_mode),
    .tx_empty    (tx_empty),
    .tx_end      (tx_end),
    .nack_flag   (nack_flag),
    .stop_flag   (stop_flag),
    .scl_hold    (scl_pull),
    .sda_drv     (sda_pull)
  );

endmodule

// File: tb/i2c_tgt_tx_bench.sv
module i2c_tgt_tx_bench;

  localparam int H  = 10;
  localparam int HQ = H / 2;

  logic        clk, rst_n;
  logic        scl_m, sda_m;
  wire         scl_i, sda_i;
  logic        scl_pull, sda_pull;
  logic [20:0] own_addr;
  logic [2:0]  own_en;
  logic        gc_en, host_en, nack_addr, nack_det_en;
  logic        tx_wr, rx_rd, clr_nack, clr_stop;
  logic [7:0]  tx_data, rx_data;
  logic [4:0]  hit_flags;
  logic        tx_mode, tx_empty, tx_end, nack_flag, stop_flag;

  int checks = 0;
  int fails  = 0;

  logic [4:0] cap_hits;
  logic       cap_txm, cap_txe;

  assign scl_i = scl_m & ~scl_pull;
  assign sda_i = sda_m & ~sda_pull;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  i2c_tgt_tx u_i2c_tgt_tx (
    .clk (clk), .rst_n (rst_n), .scl_i (scl_i), .sda_i (sda_i),
    .scl_pull (scl_pull), .sda_pull (sda_pull), .own_addr (own_addr),
    .own_en (own_en), .gc_en (gc_en), .host_en (host_en),
    .nack_addr (nack_addr), .nack_det_en (nack_det_en), .tx_wr (tx_wr),
    .tx_data (tx_data), .rx_rd (rx_rd), .rx_data (rx_data),
    .hit_flags (hit_flags), .tx_mode (tx_mode), .tx_empty (tx_empty),
    .tx_end (tx_end), .nack_flag (nack_flag), .stop_flag (stop_flag),
    .clr_nack (clr_nack), .clr_stop (clr_stop)
  );

  // {addr[6:0], rw, expected ack (1 = acked), expected hits[4:0], expects transmit mode}
  localparam logic [14:0] VEC [0:6] = '{
    {7'h21, 1'b1, 1'b1, 5'b00001, 1'b1},
    {7'h3A, 1'b0, 1'b1, 5'b00010, 1'b0},
    {7'h52, 1'b1, 1'b1, 5'b00100, 1'b1},
    {7'h00, 1'b0, 1'b1, 5'b01000, 1'b0},
    {7'h08, 1'b1, 1'b1, 5'b10000, 1'b1},
    {7'h55, 1'b1, 1'b0, 5'b00000, 1'b0},
    {7'h20, 1'b1, 1'b0, 5'b00000, 1'b0}
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    while (!scl_i) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    waitc(HQ); sda_m = b; waitc(HQ);
    scl_m = 1'b1; wait_high(); waitc(H); scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    waitc(HQ); sda_m = 1'b1; waitc(HQ);
    scl_m = 1'b1; wait_high(); waitc(HQ);
    b = sda_i; cap_hits = hit_flags; cap_txm = tx_mode; cap_txe = tx_empty;
    waitc(HQ); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; waitc(H);
    sda_m = 1'b0; waitc(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    waitc(HQ); sda_m = 1'b0; waitc(HQ);
    scl_m = 1'b1; wait_high(); waitc(H); sda_m = 1'b1; waitc(H);
  endtask

  task automatic write_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~mack);
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    tx_data = d; tx_wr = 1'b1; waitc(1); tx_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    rx_rd = 1'b1; waitc(1); rx_rd = 1'b0;
  endtask

  task automatic pulse_clr_stop();
    clr_stop = 1'b1; waitc(1); clr_stop = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    own_addr = {7'h52, 7'h3A, 7'h21}; own_en = 3'b111;
    gc_en = 1'b1; host_en = 1'b1; nack_addr = 1'b0; nack_det_en = 1'b1;
    tx_wr = 1'b0; rx_rd = 1'b0; clr_nack = 1'b0; clr_stop = 1'b0; tx_data = '0;
    waitc(5);
    rst_n = 1'b1;
    waitc(5);

    // R1 reset state
    chk("R1 flags", {hit_flags, tx_mode, tx_empty, tx_end, nack_flag, stop_flag}, '0);
    chk("R1 lines", {scl_pull, sda_pull}, 2'b00);

    // table of address patterns (R2, R3, R4, R10, R11)
    for (int i = 0; i < 7; i++) begin
      logic [14:0] v;
      v = VEC[i];
      bus_start();
      write_byte(v[14:7], ack);
      chk("R3 address ack", ack, v[6]);
      chk("R2 hit flags", cap_hits, v[5:1]);
      chk("R4 tx mode", {cap_txm, cap_txe}, {v[0], v[0]});
      chk("R10 rx data", rx_data, v[14:7]);
      waitc(2 * H);
      if (v[0]) begin
        chk("R7 hold after read address", scl_pull, 1'b1);
        pulse_rd();
        waitc(4);
        chk("R10 release on dummy read", scl_pull, 1'b0);
      end
      bus_stop();
      waitc(4);
      chk("R11 stop clears", {hit_flags, tx_mode, tx_empty, stop_flag}, 8'b00000001);
      pulse_clr_stop();
    end

    // R3: NACK answer on a matched read
    nack_addr = 1'b1;
    bus_start();
    write_byte({7'h21, 1'b1}, ack);
    chk("R3 nack answer", ack, 1'b0);
    chk("R2 hit with nack", cap_hits, 5'b00001);
    chk("R4 no tx mode on nack", cap_txm, 1'b0);
    waitc(2 * H);
    chk("R4 no hold on nack", scl_pull, 1'b0);
    bus_stop();
    pulse_clr_stop();
    nack_addr = 1'b0;

    // R2: disabled slot and disabled general call
    own_en = 3'b110; gc_en = 1'b0;
    bus_start();
    write_byte({7'h21, 1'b1}, ack);
    chk("R2 disabled slot", {ack, cap_hits}, 6'b0);
    bus_stop();
    bus_start();
    write_byte({7'h00, 1'b0}, ack);
    chk("R2 disabled general call", {ack, cap_hits}, 6'b0);
    bus_stop();
    pulse_clr_stop();
    own_en = 3'b111; gc_en = 1'b1;

    // R5/R6/R7/R10/R11: write ignored while idle, stretch, stream, end
    pulse_wr(8'hA5);
    bus_start();
    write_byte({7'h21, 1'b1}, ack);
    waitc(2 * H);
    chk("R5 idle write dropped (hold)", scl_pull, 1'b1);
    pulse_wr(8'hC3);
    waitc(4);
    chk("R7 write releases hold", scl_pull, 1'b0);
    chk("R5 empty after load", tx_empty, 1'b1);
    fork
      read_byte(1'b1, d);
      begin
        waitc(3 * H);
        pulse_wr(8'h5A);
        waitc(2);
        pulse_wr(8'hFF);
      end
    join
    chk("R6 first byte", d, 8'hC3);
    chk("R7 no tx_end while buffered", tx_end, 1'b0);
    read_byte(1'b1, d);
    chk("R5 full write dropped", d, 8'h5A);
    waitc(2 * H);
    chk("R7 hold when empty", scl_pull, 1'b1);
    chk("R7 tx_end", tx_end, 1'b1);
    waitc(3 * H);
    chk("R7 still held", scl_pull, 1'b1);
    pulse_rd();
    waitc(4);
    chk("R10 dummy read release", scl_pull, 1'b0);
    chk("R10 rx data", rx_data, 8'h43);
    bus_stop();
    waitc(4);
    chk("R11 stop state", {hit_flags, tx_mode, tx_empty, tx_end, stop_flag}, 9'b000000001);
    waitc(20);
    chk("R12 stop flag sticky", stop_flag, 1'b1);
    pulse_clr_stop();
    waitc(2);
    chk("R12 stop flag cleared", stop_flag, 1'b0);

    // R8: NACK with detection on aborts the buffered byte
    nack_det_en = 1'b1;
    bus_start();
    write_byte({7'h3A, 1'b1}, ack);
    waitc(2 * H);
    pulse_wr(8'h11);
    waitc(4);
    pulse_wr(8'h22);
    read_byte(1'b0, d);
    chk("R6 byte before nack", d, 8'h11);
    waitc(2 * H);
    chk("R8 nack flag", nack_flag, 1'b1);
    chk("R8 hold on nack", scl_pull, 1'b1);
    chk("R8 tx_end with buffer full", tx_end, 1'b0);
    waitc(4 * H);
    chk("R8 next byte not sent", {scl_pull, sda_pull}, 2'b10);
    pulse_rd();
    waitc(4);
    chk("R10 release after nack", scl_pull, 1'b0);
    bus_stop();
    waitc(20);
    chk("R12 nack flag sticky", nack_flag, 1'b1);
    clr_nack = 1'b1; waitc(1); clr_nack = 1'b0;
    waitc(2);
    chk("R12 nack flag cleared", nack_flag, 1'b0);
    pulse_clr_stop();

    // R9: NACK with detection off continues
    nack_det_en = 1'b0;
    bus_start();
    write_byte({7'h52, 1'b1}, ack);
    waitc(2 * H);
    pulse_wr(8'h33);
    waitc(4);
    pulse_wr(8'h44);
    read_byte(1'b0, d);
    chk("R9 first byte", d, 8'h33);
    read_byte(1'b1, d);
    chk("R9 continued after nack", d, 8'h44);
    chk("R9 no nack flag", nack_flag, 1'b0);
    waitc(2 * H);
    chk("R7 hold at end", {scl_pull, tx_end}, 2'b11);
    pulse_rd();
    waitc(4);
    bus_stop();
    waitc(4);
    chk("R11 stop after read", {tx_mode, tx_end, stop_flag}, 3'b001);

    summary();
    $finish;
  end

endmodule